// File: doc/BRIEF.md
# Transient and Late-Arrival Capture Monitor

This block guards a bank of capture flip-flops against two kinds of corruption. The first is a short glitch on a combinational output that happens to be sampled. The second is a transition that arrives after the latching edge. For every guarded bit the block receives two lines: the live combinational value and the value the flip-flop captured from it. In a healthy circuit nothing moves after the latching edge, so the two lines of every pair agree for a while afterwards. A disagreement in that interval shows that the captured value is wrong.

The block runs on a fast sampling clock. The functional latching edge reaches it as a one-cycle strobe. After each strobe the block opens a monitoring window of a fixed number of sampling cycles. That length is set to cover the widest expected glitch or the longest expected path delay. Outside the window the block ignores the pairs. Inside the window, any pair that disagrees sets a sticky error flag. The first rise of that flag also raises a retry request. The surrounding system can use the request to repeat the last operation at a slower clock.

Top module: `transient_capture_monitor`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, `mon_en`, `err_flag` and `retry_req` are all low.
- R2: A high `edge_stb` sampled at a clock edge drives `mon_en` high for exactly `WIN_LEN` sampling cycles, starting right after that edge. A strobe that arrives while the window is open restarts the full `WIN_LEN` count from that strobe.
- R3: A pair that disagrees while `mon_en` is low has no effect: `err_flag` and `retry_req` stay low.
- R4: If `comb_line[i]` differs from `cap_line[i]` for any lane `i` while `mon_en` is high, `err_flag` is high from the next clock edge.
- R5: While every lane of `comb_line` equals the matching lane of `cap_line`, `err_flag` never rises, whatever the data pattern.
- R6: `err_flag` stays high until `clr` is sampled high. A high `clr` forces `err_flag` and `retry_req` low at the next edge, even if a mismatch is seen in the same cycle.
- R7: `retry_req` rises together with `err_flag` whenever the flag goes from low to high. It stays high until the edge that samples the next `edge_stb`, and is low after that edge. A mismatch while the flag is already high does not raise it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_stb | input | 1 | One-cycle marker of the functional latching edge |
| clr | input | 1 | Synchronous clear of the error flag and the retry request |
| comb_line | input | NPAIRS | Live combinational outputs, one bit per lane |
| cap_line | input | NPAIRS | Captured flip-flop outputs, one bit per lane |
| mon_en | output | 1 | High during the monitoring window |
| err_flag | output | 1 | Sticky error indication |
| retry_req | output | 1 | Request to repeat the last operation at a slower clock |

## Verification
The bench builds the block with `NPAIRS=4` and `WIN_LEN=3`, and uses a functional period of six sampling cycles. With so few lanes and cycles, a single-cycle mismatch can be placed on every lane at every offset of the period. That covers the cycle just before the window opens, the first and last window cycles, and the cycles after the window closes. The small window also makes the restart case, the clear-wins case and the repeat-without-retry case short enough to run directly.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  typedef enum logic {
    PH_NORMAL  = 1'b0,
    PH_MONITOR = 1'b1
  } phase_e;

  // width needed to hold a count from 0 up to n inclusive
  function automatic int cnt_width(input int n);
    int w;
    w = $clog2(n + 1);
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/tcm_window.sv
module tcm_window
  import tcm_pkg::*;
#(
  parameter int WIN_LEN = 12
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   edge_stb,
  output phase_e phase
);
  localparam int CNT_W = cnt_width(WIN_LEN);

  logic [CNT_W-1:0] remain_q;
  logic             window_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (edge_stb) begin
      remain_q <= CNT_W'(WIN_LEN);
    end else if (remain_q != '0) begin
      remain_q <= remain_q - CNT_W'(1);
    end
  end

  assign window_open = (remain_q != '0);
  assign phase       = window_open ? PH_MONITOR : PH_NORMAL;

  // length of the current open run, counted from its strobe
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= '0;
    else if (edge_stb) run_q <= '0;
    else if (window_open) run_q <= run_q + (CNT_W+1)'(1);
    else               run_q <= '0;
  end

  AST_OPEN_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |=> (phase == PH_MONITOR)); // R2
  AST_WINDOW_NOT_TOO_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_MONITOR) |-> (run_q < (CNT_W+1)'(WIN_LEN))); // R2
  AST_WINDOW_NOT_TOO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_MONITOR) && (run_q + (CNT_W+1)'(1) < (CNT_W+1)'(WIN_LEN))) |=> (phase == PH_MONITOR)); // R2

endmodule

// File: rtl/tcm_compare.sv
module tcm_compare
  import tcm_pkg::*;
#(
  parameter int NPAIRS = 72
) (
  input  phase_e            phase,
  input  logic [NPAIRS-1:0] comb_line,
  input  logic [NPAIRS-1:0] cap_line,
  output logic [NPAIRS-1:0] lane_diff,
  output logic              hit
);
  for (genvar i = 0; i < NPAIRS; i++) begin : g_lane
    assign lane_diff[i] = comb_line[i] ^ cap_line[i];
  end

  assign hit = (phase == PH_MONITOR) && (|lane_diff);

endmodule

// File: rtl/tcm_flag.sv
module tcm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_stb,
  input  logic clr,
  input  logic hit,
  output logic err_flag,
  output logic retry_req
);
  logic flag_q;
  logic retry_q;
  logic first_rise;

  assign first_rise = hit && !flag_q && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (clr) flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          retry_q <= 1'b0;
    else if (clr)        retry_q <= 1'b0;
    else if (first_rise) retry_q <= 1'b1;
    else if (edge_stb)   retry_q <= 1'b0;
  end

  assign err_flag  = flag_q;
  assign retry_req = retry_q;

  AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> err_flag); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr) |=> err_flag); // R6
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!err_flag && !retry_req)); // R6
  AST_RETRY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> retry_req); // R7
  AST_RETRY_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> err_flag); // R7

endmodule

// File: rtl/transient_capture_monitor.sv
module transient_capture_monitor
  import tcm_pkg::*;
#(
  parameter int NPAIRS  = 72,
  parameter int WIN_LEN = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_stb,
  input  logic              clr,
  input  logic [NPAIRS-1:0] comb_line,
  input  logic [NPAIRS-1:0] cap_line,
  output logic              mon_en,
  output logic              err_flag,
  output logic              retry_req
);
  phase_e            phase;
  logic [NPAIRS-1:0] lane_diff;
  logic              hit;

  tcm_window #(.WIN_LEN(WIN_LEN)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_stb (edge_stb),
    .phase    (phase)
  );

  tcm_compare #(.NPAIRS(NPAIRS)) u_compare (
    .phase     (phase),
    .comb_line (comb_line),
    .cap_line  (cap_line),
    .lane_diff (lane_diff),
    .hit       (hit)
  );

  tcm_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_stb  (edge_stb),
    .clr       (clr),
    .hit       (hit),
    .err_flag  (err_flag),
    .retry_req (retry_req)
  );

  assign mon_en = (phase == PH_MONITOR);

  AST_IGNORE_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en && !err_flag) |=> !err_flag); // R3
  AST_CLEAN_PAIRS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((comb_line == cap_line) && !err_flag) |=> !err_flag); // R5
  AST_LANES_REACH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && (lane_diff != '0)) |-> hit); // R4

endmodule

// File: tb/transient_capture_monitor_tb.sv
module transient_capture_monitor_tb;
  localparam int NP  = 4;
  localparam int W   = 3;
  localparam int PER = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          edge_stb = 1'b0;
  logic          clr = 1'b0;
  logic [NP-1:0] comb_line = '0;
  logic [NP-1:0] cap_line = '0;
  logic          mon_en, err_flag, retry_req;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  transient_capture_monitor #(.NPAIRS(NP), .WIN_LEN(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .edge_stb(edge_stb), .clr(clr),
    .comb_line(comb_line), .cap_line(cap_line),
    .mon_en(mon_en), .err_flag(err_flag), .retry_req(retry_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one functional period; strobe at cycle 0, optional extra strobe,
  // single-cycle mismatch on lane at cycle off (off<0: none)
  task automatic frame(input int lane, input int off, input int len, input int stb2);
    for (int c = 0; c < len; c++) begin
      logic [NP-1:0] pat;
      int lo, hi;
      pat = NP'((c * 5 + lane * 3 + 1) % (1 << NP));
      edge_stb  = (c == 0) || (c == stb2);
      comb_line = pat;
      cap_line  = (c == off) ? (pat ^ NP'(1 << lane)) : pat;
      lo = 1;
      hi = (stb2 > 0) ? stb2 + W : W;
      #1;
      chk("R2 window", int'(mon_en), int'(c >= lo && c <= hi));
      tick();
    end
    edge_stb = 1'b0;
    cap_line = comb_line;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    tick();
    clr = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    // R1: outputs low during reset
    chk("R1 mon_en", int'(mon_en), 0);
    chk("R1 err_flag", int'(err_flag), 0);
    chk("R1 retry_req", int'(retry_req), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 after release", int'(err_flag | retry_req | mon_en), 0);

    // R3 R4 R7 sweep: every lane, every offset in the period
    for (int lane = 0; lane < NP; lane++) begin
      for (int off = 0; off < PER; off++) begin
        int exp;
        exp = (off >= 1 && off <= W) ? 1 : 0;
        do_clear();
        frame(lane, off, PER, -1);
        chk(exp ? "R4 flag set" : "R3 flag ignored", int'(err_flag), exp);
        chk("R7 retry rise", int'(retry_req), exp);
        frame(lane, -1, PER, -1);
        chk("R6 sticky", int'(err_flag), exp);
        chk("R7 retry dropped after strobe", int'(retry_req), 0);
      end
    end

    // R5: clean pairs with varying data never flag
    do_clear();
    for (int lane = 0; lane < NP; lane++) frame(lane, -1, PER, -1);
    chk("R5 clean", int'(err_flag), 0);
    chk("R5 clean retry", int'(retry_req), 0);

    // R2 restart: second strobe at cycle 2, mismatch on last extended cycle
    do_clear();
    frame(2, 2 + W, 2 + W + 2, 2);
    chk("R2 restart extends window", int'(err_flag), 1);

    // R6: clear beats a simultaneous hit
    do_clear();
    edge_stb = 1'b1;
    tick();
    edge_stb = 1'b0;
    cap_line = comb_line ^ NP'(1);
    clr = 1'b1;
    tick();
    clr = 1'b0;
    cap_line = comb_line;
    chk("R6 clear wins flag", int'(err_flag), 0);
    chk("R6 clear wins retry", int'(retry_req), 0);
    tick();
    tick();

    // R7: second hit while flag already high does not re-raise retry
    do_clear();
    frame(1, 1, PER, -1);
    chk("R7 first rise", int'(retry_req), 1);
    frame(3, 2, PER, -1);
    chk("R7 no repeat retry", int'(retry_req), 0);
    chk("R6 still set", int'(err_flag), 1);
    do_clear();
    chk("R6 cleared", int'(err_flag), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule